// File: doc/BRIEF.md
# Running Median Filter Unit

This unit keeps a sliding window of the most recent N unsigned samples and returns their median after every push. It holds the window twice: once as an arrival-order shift register, so the sample that is about to leave is always known, and once as a register array kept in ascending order. A push never re-sorts the window. It makes one removal and one insertion in the sorted array. Each is a single cycle of parallel comparisons followed by a one-place shift of the affected slots.

A push takes three cycles, stepped by a small state machine. From `IDLE`, an accepted push moves to `REMOVE`. In `REMOVE` the departing sample is deleted from the sorted array and the slots above it move down. This happens only when the window is full. `INSERT` follows. It locates the new sample's position, moves the larger entries up, writes the sample and advances the arrival register. `OUTPUT` comes next and captures the middle slot into the result register. The machine then returns to `IDLE`. A clear command returns the machine to `IDLE` from any state and empties the window.

The median is reported only once N samples have entered since reset or the last clear. Before that, `full_o` and `res_valid_o` stay low.

Top module: `med_filter_top`

## Requirements
- R1: After reset, `busy_o`, `res_valid_o` and `full_o` are all low.
- R2: A push accepted in `IDLE` (push_i high, clear_i low) raises `busy_o` for exactly three consecutive cycles (`REMOVE`, `INSERT`, `OUTPUT`), after which the unit is back in `IDLE`.
- R3: A push that arrives while `busy_o` is high is ignored: it neither enters the window nor changes any later median.
- R4: `full_o` and `res_valid_o` stay low until the N-th push since reset or clear has completed. From that push on, `full_o` stays high until a clear.
- R5: `res_valid_o` is a one-cycle pulse in the cycle right after the last busy cycle of a push. `res_o` then holds the entry at index (N-1)/2 of the ascending-sorted window (default N=7, index 3) and keeps that value until the next result.
- R6: Once the window is full, each push replaces the oldest sample. If that value appears more than once, exactly one copy is removed.
- R7: Clear empties the window, aborts a push in progress, drops `busy_o`, `full_o` and `res_valid_o` in the next cycle, and wins over a push in the same cycle.
- R8: Equal samples are kept as separate entries, so a window of repeated values yields that value as its median.
- R9: Samples are unsigned 16-bit. 0 and 65535 sort as the smallest and largest values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Push `sample_i` into the window (taken only in `IDLE`) |
| clear_i | input | 1 | Empty the window and abort any push |
| sample_i | input | 16 | New sample value |
| busy_o | output | 1 | High while a push is being processed |
| res_valid_o | output | 1 | One-cycle pulse when `res_o` carries a new median |
| res_o | output | 16 | Latest median |
| full_o | output | 1 | Window holds N samples |

## Verification
A push is taken at the clock edge where `push_i` is sampled in `IDLE`. `busy_o` is high after that edge and after the next two. The result pulse and the new `res_o` appear after the fourth edge, and `full_o` changes after the third. The bench drives inputs on falling edges and samples on falling edges. For every push it checks `busy_o` at the three falling edges that follow the push, then checks `res_valid_o` and `res_o` at the fourth. A clear is checked one falling edge after it is driven.

// File: rtl/med_pkg.sv
package med_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_REMOVE = 2'd1,
        ST_INSERT = 2'd2,
        ST_OUTPUT = 2'd3
    } med_state_e;
endpackage

// File: rtl/med_age_fifo.sv
module med_age_fifo #(
    parameter int W  = 16,
    parameter int N  = 7,
    parameter int CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          shift_i,
    input  logic [W-1:0]  sample_i,
    output logic [W-1:0]  oldest_o,
    output logic [CW-1:0] count_o,
    output logic          full_o
);
    localparam logic [CW-1:0] FULL_CNT = CW'(N);

    logic [W-1:0]  age_q [N];
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int j = 0; j < N; j++) age_q[j] <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (shift_i) begin
            age_q[0] <= sample_i;
            for (int j = 1; j < N; j++) age_q[j] <= age_q[j-1];
            if (cnt_q != FULL_CNT) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign oldest_o = age_q[N-1];
    assign count_o  = cnt_q;
    assign full_o   = (cnt_q == FULL_CNT);
endmodule

// File: rtl/med_sort_array.sv
module med_sort_array #(
    parameter int W  = 16,
    parameter int N  = 7,
    parameter int CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          remove_i,
    input  logic          insert_i,
    input  logic [W-1:0]  old_i,
    input  logic [W-1:0]  new_i,
    input  logic [CW-1:0] used_i,
    output logic [W-1:0]  median_o
);
    localparam int MID = (N - 1) / 2;

    logic [W-1:0] slot_q   [N];
    logic [W-1:0] nxt_rm   [N];
    logic [W-1:0] nxt_ins  [N];
    logic [N-1:0] at_rm;
    logic [N-1:0] above;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_slot
            // removal: slots from the first match upwards take their upper neighbour
            if (g == 0) begin : g_rm0
                assign at_rm[g] = (slot_q[g] == old_i);
            end else begin : g_rmn
                assign at_rm[g] = at_rm[g-1] | (slot_q[g] == old_i);
            end
            if (g == N - 1) begin : g_top
                assign nxt_rm[g] = slot_q[g];
            end else begin : g_mid
                assign nxt_rm[g] = at_rm[g] ? slot_q[g+1] : slot_q[g];
            end

            // insertion: unused slots count as larger than the new sample
            assign above[g] = (CW'(g) >= used_i) || (slot_q[g] > new_i);
            if (g == 0) begin : g_ins0
                assign nxt_ins[g] = above[g] ? new_i : slot_q[g];
            end else begin : g_insn
                assign nxt_ins[g] = !above[g]    ? slot_q[g]   :
                                    above[g-1]   ? slot_q[g-1] : new_i;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < N; j++) slot_q[j] <= '0;
        end else if (remove_i) begin
            for (int j = 0; j < N; j++) slot_q[j] <= nxt_rm[j];
        end else if (insert_i) begin
            for (int j = 0; j < N; j++) slot_q[j] <= nxt_ins[j];
        end
    end

    assign median_o = slot_q[MID];
endmodule

// File: rtl/med_ctrl.sv
module med_ctrl
    import med_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         clear_i,
    input  logic [W-1:0] sample_i,
    input  logic         full_i,
    input  logic [W-1:0] median_i,
    output logic         busy_o,
    output logic         remove_o,
    output logic         insert_o,
    output logic [W-1:0] held_o,
    output logic         res_valid_o,
    output logic [W-1:0] res_o
);
    med_state_e state_q, state_d;
    logic [W-1:0] held_q;
    logic [W-1:0] res_q;
    logic         vld_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (push_i) state_d = ST_REMOVE;
            ST_REMOVE: state_d = ST_INSERT;
            ST_INSERT: state_d = ST_OUTPUT;
            ST_OUTPUT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
        if (clear_i) state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            held_q  <= '0;
            res_q   <= '0;
            vld_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            vld_q   <= 1'b0;
            if (!clear_i) begin
                if (state_q == ST_IDLE && push_i) held_q <= sample_i;
                if (state_q == ST_OUTPUT) begin
                    vld_q <= full_i;
                    if (full_i) res_q <= median_i;
                end
            end
        end
    end

    always_comb begin
        busy_o   = (state_q != ST_IDLE);
        remove_o = (state_q == ST_REMOVE) && full_i && !clear_i;
        insert_o = (state_q == ST_INSERT) && !clear_i;
    end

    assign held_o      = held_q;
    assign res_valid_o = vld_q;
    assign res_o       = res_q;
endmodule

// File: rtl/med_filter_top.sv
module med_filter_top #(
    parameter int W = 16,
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         clear_i,
    input  logic [W-1:0] sample_i,
    output logic         busy_o,
    output logic         res_valid_o,
    output logic [W-1:0] res_o,
    output logic         full_o
);
    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    logic          remove_en, insert_en, win_full;
    logic [W-1:0]  held, oldest, median;
    logic [CW-1:0] fill;
    logic [CW-1:0] used;

    // after a removal only N-1 sorted entries remain valid
    assign used = win_full ? LAST : fill;

    med_ctrl #(.W(W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .clear_i(clear_i),
        .sample_i(sample_i), .full_i(win_full), .median_i(median),
        .busy_o(busy_o), .remove_o(remove_en), .insert_o(insert_en),
        .held_o(held), .res_valid_o(res_valid_o), .res_o(res_o)
    );

    med_age_fifo #(.W(W), .N(N), .CW(CW)) fifo_i (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .shift_i(insert_en),
        .sample_i(held), .oldest_o(oldest), .count_o(fill), .full_o(win_full)
    );

    med_sort_array #(.W(W), .N(N), .CW(CW)) sort_i (
        .clk(clk), .rst_n(rst_n), .remove_i(remove_en), .insert_i(insert_en),
        .old_i(oldest), .new_i(held), .used_i(used), .median_o(median)
    );

    assign full_o = win_full;
endmodule

// File: rtl/med_filter_checker.sv
module med_filter_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         push_i,
    input logic         clear_i,
    input logic         busy_o,
    input logic         res_valid_o,
    input logic [W-1:0] res_o,
    input logic         full_o
);
    a_r2_busy_three: assert property (@(posedge clk) disable iff (!rst_n || clear_i)
        $rose(busy_o) |=> busy_o ##1 busy_o ##1 !busy_o);

    a_r4_valid_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> full_o);

    a_r4_full_steady_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !push_i && !clear_i) |=> $stable(full_o));

    a_r5_valid_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> (!busy_o && $past(busy_o)));

    a_r5_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_valid_o && !clear_i) |=> (res_valid_o || $stable(res_o)));

    a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (!busy_o && !full_o && !res_valid_o));
endmodule

bind med_filter_top med_filter_checker #(.W(W)) chk_i (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .clear_i(clear_i),
    .busy_o(busy_o), .res_valid_o(res_valid_o), .res_o(res_o), .full_o(full_o)
);

// File: tb/med_filter_top_tb_top.sv
module med_filter_top_tb_top;
    localparam int W = 16;
    localparam int N = 7;
    localparam int NV = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         push_i = 1'b0;
    logic         clear_i = 1'b0;
    logic [W-1:0] sample_i = '0;
    logic         busy_o, res_valid_o, full_o;
    logic [W-1:0] res_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    med_filter_top #(.W(W), .N(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .clear_i(clear_i),
        .sample_i(sample_i), .busy_o(busy_o), .res_valid_o(res_valid_o),
        .res_o(res_o), .full_o(full_o)
    );

    // {expected valid, sample, expected median}
    localparam logic [2*W:0] VEC [NV] = '{
        {1'b0, 16'd50,    16'd0},
        {1'b0, 16'd10,    16'd0},
        {1'b0, 16'd90,    16'd0},
        {1'b0, 16'd30,    16'd0},
        {1'b0, 16'd70,    16'd0},
        {1'b0, 16'd20,    16'd0},
        {1'b1, 16'd60,    16'd50},
        {1'b1, 16'd40,    16'd40},
        {1'b1, 16'd40,    16'd40},
        {1'b1, 16'd5,     16'd40},
        {1'b1, 16'd65535, 16'd40},
        {1'b1, 16'd0,     16'd40},
        {1'b1, 16'd100,   16'd40},
        {1'b1, 16'd200,   16'd40},
        {1'b1, 16'd300,   16'd100},
        {1'b1, 16'd300,   16'd200}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // drive a push; optionally inject a second push during busy
    task automatic push(input logic [W-1:0] s, input bit exp_v, input logic [W-1:0] exp_m,
                        input bit inject, input string tag);
        @(negedge clk); push_i = 1'b1; sample_i = s;
        @(negedge clk); push_i = inject; sample_i = 16'd0;
        check({tag, " R2 busy c1"}, busy_o, 1);
        @(negedge clk); push_i = 1'b0;
        check({tag, " R2 busy c2"}, busy_o, 1);
        @(negedge clk);
        check({tag, " R2 busy c3"}, busy_o, 1);
        @(negedge clk);
        check({tag, " R2 idle"}, busy_o, 0);
        check({tag, " R4 valid"}, res_valid_o, exp_v);
        if (exp_v) check({tag, " R5 median"}, res_o, exp_m);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy", busy_o, 0);
        check("R1 valid", res_valid_o, 0);
        check("R1 full", full_o, 0);

        // table walk: fill, steady state, duplicates (R6, R8), extremes (R9)
        for (int i = 0; i < NV; i++) begin
            push(VEC[i][2*W-1:W], VEC[i][2*W], VEC[i][W-1:0], 1'b0, $sformatf("vec%0d R6 R9", i));
            check($sformatf("vec%0d R4 full", i), full_o, (i >= N - 1));
        end

        // R5: result held after the pulse
        @(negedge clk);
        check("R5 pulse gone", res_valid_o, 0);
        check("R5 hold", res_o, 200);

        // R3: window 5,65535,0,100,200,300,300; push 1000, inject 0 while busy
        push(16'd1000, 1'b1, 16'd300, 1'b1, "R3 first");
        push(16'd7, 1'b1, 16'd200, 1'b0, "R3 follow");

        // R7: clear mid-push and clear beating a push
        @(negedge clk); push_i = 1'b1; sample_i = 16'd9;
        @(negedge clk); push_i = 1'b0; clear_i = 1'b1;
        @(negedge clk); clear_i = 1'b0;
        check("R7 busy", busy_o, 0);
        check("R7 full", full_o, 0);
        check("R7 valid", res_valid_o, 0);
        @(negedge clk); push_i = 1'b1; clear_i = 1'b1; sample_i = 16'd4;
        @(negedge clk); push_i = 1'b0; clear_i = 1'b0;
        check("R7 clear wins", busy_o, 0);

        // R8: ties after clear, refill from empty (R4)
        push(16'd3, 1'b0, 16'd0, 1'b0, "R8 a");
        push(16'd3, 1'b0, 16'd0, 1'b0, "R8 b");
        push(16'd3, 1'b0, 16'd0, 1'b0, "R8 c");
        push(16'd1, 1'b0, 16'd0, 1'b0, "R8 d");
        push(16'd1, 1'b0, 16'd0, 1'b0, "R8 e");
        push(16'd1, 1'b0, 16'd0, 1'b0, "R8 f");
        check("R4 not full at N-1", full_o, 0);
        push(16'd2, 1'b1, 16'd2, 1'b0, "R8 g");
        check("R4 full at N", full_o, 1);
        push(16'd1, 1'b1, 16'd1, 1'b0, "R6 R8 h");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule